// File: doc/BRIEF.md
# Sampled Port Level-Change Interrupt

This block watches a small input port and raises a single shared interrupt when the combined activity of the enabled port bits flips. A bit counts as "active" when it is high under the pull-down setting, or low under the pull-up setting. The block ORs the enabled, polarity-adjusted bits into one aggregate value. It keeps the aggregate from the previous sampling edge and compares it with the current one. A mismatch is a detected event.

Detection takes place only on a sampling tick. A tick is a one-cycle strobe that marks the falling edge of a slow time-base output. Two such strobes arrive, a slow one (about 128 Hz) and a fast one (about 4 kHz), and a rate select picks one of them. Each event sets a sticky request flag and emits a one-cycle pulse toward the priority logic. The flag stays set until software clears it. The request output is the flag gated by a master enable, and it is presented with the fixed vector code 0x001E.

All bits share one flag, so software reads the sampled port value to find the bit that caused the event. When the enable mask, the pull select or the rate select changes, the stored aggregate is reloaded from the current inputs, so reconfiguration never raises an interrupt by itself.

Top module: `port_chg_irq`

## Requirements
- R1: While reset is asserted and right after it is released, flag_o, pulse_o and irq_o are 0, and port_q_o is 0.
- R2: With pull_up_i = 0, if every enabled bit was low at the previous tick and at least one enabled bit is high at a tick, flag_o and pulse_o go to 1 in the cycle after that tick.
- R3: With pull_up_i = 0, if at least one enabled bit was high at the previous tick and all enabled bits are low at a tick, flag_o and pulse_o go to 1 in the cycle after that tick.
- R4: With pull_up_i = 1, the same two rules hold with the levels swapped: all high to any low fires, and any low to all high fires.
- R5: A bit whose bit_en_i bit is 0 has no effect on detection.
- R6: Detection and port capture happen only in a cycle where the selected tick is 1. rate_fast_i = 1 selects tick_hi_i and rate_fast_i = 0 selects tick_lo_i. The unselected tick has no effect.
- R7: flag_o stays 1 until a cycle with clr_i = 1 clears it in the next cycle. If an event and clr_i occur in the same cycle, flag_o stays 1.
- R8: pulse_o is 1 for exactly the cycle after each event and is 0 otherwise.
- R9: irq_o equals flag_o AND mie_i. The flag still records events while mie_i = 0.
- R10: In a cycle where bit_en_i, pull_up_i or rate_fast_i differs from its value in the previous cycle, no event is raised. The stored aggregate is reloaded from the current port_i, so a later tick with unchanged inputs raises no event.
- R11: vector_o is always 16'h001E.
- R12: port_q_o takes the value of port_i in the cycle after each selected tick and otherwise holds.
- R13: At a tick where the aggregate stays active, a change in which enabled bits are active raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_i | input | 4 | Raw port input levels |
| bit_en_i | input | 4 | Per-bit participation enable |
| pull_up_i | input | 1 | 0: active means high; 1: active means low |
| rate_fast_i | input | 1 | 1: sample on the fast tick; 0: on the slow tick |
| tick_lo_i | input | 1 | One-cycle strobe at the slow sampling-clock falling edge |
| tick_hi_i | input | 1 | One-cycle strobe at the fast sampling-clock falling edge |
| clr_i | input | 1 | Software clear strobe for the request flag |
| mie_i | input | 1 | Master interrupt enable |
| port_q_o | output | 4 | Port value captured at the latest selected tick |
| flag_o | output | 1 | Sticky request flag |
| pulse_o | output | 1 | One-cycle event pulse toward the priority logic |
| irq_o | output | 1 | Request to the priority logic (flag AND master enable) |
| vector_o | output | 16 | Fixed vector code |

## Verification
Every registered result (flag_o, pulse_o and port_q_o) changes one clock after the cycle that holds the tick, the clear or the configuration change. irq_o follows flag_o and mie_i in that same cycle. The driver applies each cycle's inputs on the falling edge and queues the outputs expected after the next rising edge. The monitor pops and compares them 1 ns after that rising edge, so each expectation is checked in exactly the cycle where it is due. Reset values are checked directly while reset is held.

// File: rtl/lcirq_pkg.sv
package lcirq_pkg;
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] IRQ_VEC = 16'h001E;

  typedef struct packed {
    logic pull_up;
    logic rate_fast;
  } mode_t;
endpackage

// File: rtl/lcirq_rst_sync.sv
module lcirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sr_q <= '0;
    else          sr_q <= sr_d;
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/lcirq_tick_sel.sv
module lcirq_tick_sel (
  input  logic tick_lo_i,
  input  logic tick_hi_i,
  input  logic rate_fast_i,
  output logic samp_o
);
  always_comb begin
    samp_o = rate_fast_i ? tick_hi_i : tick_lo_i;
  end
endmodule

// File: rtl/lcirq_detect.sv
module lcirq_detect
  import lcirq_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         samp_i,
  input  logic [W-1:0] port_i,
  input  logic [W-1:0] en_i,
  input  mode_t        mode_i,
  output logic         trig_o,
  output logic [W-1:0] port_q_o
);
  localparam int CFG_W = W + $bits(mode_t);

  logic [W-1:0]     act;
  logic             agg;
  logic             cfg_chg;
  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             prev_q, prev_d;
  logic [W-1:0]     port_q, port_d;

  always_comb begin
    act     = (port_i ^ {W{mode_i.pull_up}}) & en_i;
    agg     = |act;
    cfg_now = {en_i, mode_i};
    cfg_chg = (cfg_now != cfg_q);
    prev_d  = prev_q;
    trig_o  = 1'b0;
    if (cfg_chg) begin
      prev_d = agg;
    end else if (samp_i) begin
      trig_o = (agg != prev_q);
      prev_d = agg;
    end
    port_d = samp_i ? port_i : port_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      port_q <= '0;
    end else begin
      cfg_q  <= cfg_now;
      prev_q <= prev_d;
      port_q <= port_d;
    end
  end

  assign port_q_o = port_q;

  logic reload_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= 1'b0;
    else        reload_q <= cfg_chg;
  end

  p_port_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
    samp_i |=> port_q_o == $past(port_i));
  p_port_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_i |=> $stable(port_q_o));
  p_reload_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && $stable(port_i) && !cfg_chg) |-> !trig_o);
endmodule

// File: rtl/lcirq_flag.sv
module lcirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic clr_i,
  input  logic mie_i,
  output logic flag_o,
  output logic pulse_o,
  output logic irq_o
);
  logic flag_q, flag_d;
  logic pulse_q;

  always_comb begin
    flag_d = flag_q;
    if (trig_i)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= trig_i;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
  assign irq_o   = flag_q & mie_i;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (flag_o && pulse_o));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && clr_i && !trig_i) |=> !flag_o);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_i |=> !pulse_o);
endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
  import lcirq_pkg::*;
#(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     port_i,
  input  logic [W-1:0]     bit_en_i,
  input  logic             pull_up_i,
  input  logic             rate_fast_i,
  input  logic             tick_lo_i,
  input  logic             tick_hi_i,
  input  logic             clr_i,
  input  logic             mie_i,
  output logic [W-1:0]     port_q_o,
  output logic             flag_o,
  output logic             pulse_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vector_o
);
  logic  rst_n_s;
  logic  samp;
  logic  trig;
  mode_t mode;

  assign mode.pull_up   = pull_up_i;
  assign mode.rate_fast = rate_fast_i;
  assign vector_o       = IRQ_VEC;

  lcirq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  lcirq_tick_sel u_sel (
    .tick_lo_i(tick_lo_i), .tick_hi_i(tick_hi_i),
    .rate_fast_i(rate_fast_i), .samp_o(samp)
  );

  lcirq_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_n_s), .samp_i(samp), .port_i(port_i),
    .en_i(bit_en_i), .mode_i(mode), .trig_o(trig), .port_q_o(port_q_o)
  );

  lcirq_flag u_flag (
    .clk(clk), .rst_n(rst_n_s), .trig_i(trig), .clr_i(clr_i),
    .mie_i(mie_i), .flag_o(flag_o), .pulse_o(pulse_o), .irq_o(irq_o)
  );
endmodule

// File: tb/port_chg_irq_tb.sv
module port_chg_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  port_i, bit_en_i;
  logic        pull_up_i, rate_fast_i, tick_lo_i, tick_hi_i, clr_i, mie_i;
  logic [3:0]  port_q_o;
  logic        flag_o, pulse_o, irq_o;
  logic [15:0] vector_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  port_chg_irq u_dut (
    .clk(clk), .rst_n(rst_n), .port_i(port_i), .bit_en_i(bit_en_i),
    .pull_up_i(pull_up_i), .rate_fast_i(rate_fast_i), .tick_lo_i(tick_lo_i),
    .tick_hi_i(tick_hi_i), .clr_i(clr_i), .mie_i(mie_i), .port_q_o(port_q_o),
    .flag_o(flag_o), .pulse_o(pulse_o), .irq_o(irq_o), .vector_o(vector_o)
  );

  typedef struct {
    logic       flag, pulse, irq;
    logic [3:0] portq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference state built from the requirements
  logic [5:0] m_cfg  = '0;
  logic       m_prev = 1'b0;
  logic       m_flag = 1'b0;
  logic [3:0] m_pq   = '0;

  task automatic step(input logic [3:0] p, input logic [3:0] en, input logic pu,
                      input logic fast, input logic tlo, input logic thi,
                      input logic clr, input logic mie, input string tag);
    logic agg, tk, trig;
    exp_t e;
    @(negedge clk);
    port_i = p; bit_en_i = en; pull_up_i = pu; rate_fast_i = fast;
    tick_lo_i = tlo; tick_hi_i = thi; clr_i = clr; mie_i = mie;
    agg  = |((p ^ {4{pu}}) & en);
    tk   = fast ? thi : tlo;
    trig = 1'b0;
    if ({en, pu, fast} != m_cfg) m_prev = agg;
    else if (tk) begin trig = (agg != m_prev); m_prev = agg; end
    m_cfg = {en, pu, fast};
    if (tk) m_pq = p;
    if (trig) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    e.flag = m_flag; e.pulse = trig; e.irq = m_flag & mie; e.portq = m_pq; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (flag_o !== e.flag || pulse_o !== e.pulse || irq_o !== e.irq || port_q_o !== e.portq) begin
        n_fail++;
        $display("FAIL %s: flag/pulse/irq/portq = %b/%b/%b/%h expected %b/%b/%b/%h",
                 e.tag, flag_o, pulse_o, irq_o, port_q_o, e.flag, e.pulse, e.irq, e.portq);
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    port_i = '0; bit_en_i = '0; pull_up_i = 0; rate_fast_i = 0;
    tick_lo_i = 0; tick_hi_i = 0; clr_i = 0; mie_i = 1;
    repeat (3) @(negedge clk);
    n_run++;
    if (flag_o !== 0 || pulse_o !== 0 || irq_o !== 0 || port_q_o !== 0) begin
      n_fail++;
      $display("FAIL R1: flag/pulse/irq/portq = %b/%b/%b/%h expected 0/0/0/0",
               flag_o, pulse_o, irq_o, port_q_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release, R10 enable-mask write with quiet port
    step(4'h0, 4'hF, 0, 0, 0, 0, 0, 1, "R1");
    // R6 no tick: port change ignored; unselected fast tick ignored
    step(4'h1, 4'hF, 0, 0, 0, 0, 0, 1, "R6");
    step(4'h1, 4'hF, 0, 0, 0, 1, 0, 1, "R6");
    // R2 all low -> one high at slow tick
    step(4'h1, 4'hF, 0, 0, 1, 0, 0, 1, "R2");
    step(4'h1, 4'hF, 0, 0, 0, 0, 0, 1, "R8");
    step(4'h1, 4'hF, 0, 0, 0, 0, 1, 1, "R7");
    step(4'h1, 4'hF, 0, 0, 0, 0, 0, 1, "R7");
    // R13 aggregate stays active
    step(4'h3, 4'hF, 0, 0, 1, 0, 0, 1, "R13");
    // R3 any high -> all low
    step(4'h0, 4'hF, 0, 0, 1, 0, 0, 1, "R3");
    // R7 set wins over clear in same cycle
    step(4'h1, 4'hF, 0, 0, 1, 0, 1, 1, "R7");
    step(4'h1, 4'hF, 0, 0, 0, 0, 1, 1, "R7");
    // R5 disabled bits ignored
    step(4'h1, 4'h1, 0, 0, 0, 0, 0, 1, "R10");
    step(4'h5, 4'h1, 0, 0, 1, 0, 0, 1, "R5");
    step(4'h0, 4'h1, 0, 0, 1, 0, 0, 1, "R5");
    step(4'h0, 4'h1, 0, 0, 0, 0, 1, 1, "R7");
    step(4'h4, 4'h1, 0, 0, 1, 0, 0, 1, "R5");
    // R4 pull-up on fast tick
    step(4'hF, 4'hF, 1, 1, 0, 0, 0, 1, "R10");
    step(4'hE, 4'hF, 1, 1, 1, 0, 0, 1, "R6");
    step(4'hE, 4'hF, 1, 1, 0, 1, 0, 1, "R4");
    step(4'hE, 4'hF, 1, 1, 0, 0, 1, 1, "R7");
    step(4'hF, 4'hF, 1, 1, 0, 1, 0, 1, "R4");
    step(4'hF, 4'hF, 1, 1, 0, 0, 1, 1, "R7");
    // R9 master enable off still records
    step(4'h7, 4'hF, 1, 1, 0, 1, 0, 0, "R9");
    step(4'h7, 4'hF, 1, 1, 0, 0, 0, 0, "R9");
    step(4'h7, 4'hF, 1, 1, 0, 0, 0, 1, "R9");
    step(4'h7, 4'hF, 1, 1, 0, 0, 1, 1, "R7");
    // R10 polarity switch with reload, then a quiet tick
    step(4'h0, 4'hF, 0, 1, 0, 0, 0, 1, "R10");
    step(4'h0, 4'hF, 0, 1, 0, 1, 0, 1, "R10");
    // R10 config write coinciding with a tick raises nothing
    step(4'h8, 4'hF, 0, 0, 1, 0, 0, 1, "R10");
    step(4'h8, 4'hF, 0, 0, 1, 0, 0, 1, "R12");
    @(negedge clk);
    @(negedge clk);
    n_run++;
    if (vector_o !== 16'h001E) begin
      n_fail++;
      $display("FAIL R11: vector %h expected 001e", vector_o);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule